// File: doc/BRIEF.md
# SPI Memory Write-Guard Controller

This block is the command front end of a serial non-volatile memory. It watches chip select, the serial clock and the serial data input, all sampled on the system clock. It collects an 8-bit opcode and a 24-bit address, MSB first. When chip select rises it decides whether the instruction is allowed to act. Allowed modifying instructions leave as a one-cycle start strobe carrying the opcode and the address. The memory array, the charge pumps and the real program timing are outside this block. Instead, a programmable counter stands in for the busy time.

Several guards apply before a modifying instruction (page write, page program, page erase, sector erase) can start:
- The write-enable latch must be set.
- The frame must hold a whole number of bytes.
- The target must not be a protected low page.
- The device must be neither busy nor in deep power-down.
- The active-low reset pin must be high.

A status-read instruction returns the write-enable latch and the write-in-progress flag on the serial output.

Top module: `spi_write_guard`

## Requirements
- R1: While `rst_n` is low, the write-enable latch, write-in-progress and deep power-down state are cleared, `op_start` stays 0 and `miso` stays 0. Once `rst_n` is high again, a status read returns 00h and a modifying instruction is rejected until a new write enable.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. A modifying instruction (0Ah page write, 02h page program, DBh page erase, D8h sector erase) is ignored unless the latch is set.
- R3: An instruction acts only if the number of rising `sck` edges while `cs_n` was low is a non-zero multiple of eight. A modifying instruction also needs at least 32 edges (opcode plus 24-bit address). Any other frame is discarded.
- R4: While `wp_n` is low, a modifying instruction whose address bits [23:8] are below `PROT_PAGES` (256 by default) is rejected. While `wp_n` is high, every address is accepted.
- R5: An accepted modifying instruction gives a single-cycle `op_start` in the first clock after `cs_n` is seen high. In that cycle `op_code` carries the opcode and `op_addr` carries the 24-bit address.
- R6: Opcode B9h enters deep power-down. In deep power-down, every instruction except ABh (release) is ignored, and a status read drives `miso` low.
- R7: An accepted modifying instruction sets write-in-progress for `BUSY_CYCLES` clock cycles. During that time every instruction except status read is ignored.
- R8: When write-in-progress ends, the write-enable latch clears in the same cycle.
- R9: After opcode 05h, `miso` shifts out the status byte MSB first. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7:2 are 0. Each bit changes after a falling `sck` edge, and the byte repeats while `cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are sampled on it |
| rst_n | input | 1 | Active-low reset pin, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, sampled on rising `sck` |
| wp_n | input | 1 | Write protect, low protects the lowest pages |
| miso | output | 1 | Serial data out, low when not selected |
| op_start | output | 1 | One-cycle start of an accepted modifying instruction |
| op_code | output | 8 | Opcode of the started instruction |
| op_addr | output | 24 | Address of the started instruction |

## Verification
The bench builds the block with `BUSY_CYCLES` = 200 and the default `PROT_PAGES` of 256. A busy window of 200 cycles is long enough for a complete two-byte status read and a rejected instruction to fall inside write-in-progress, and short enough that its end, and the latch clearing with it, is reached quickly. With the default page limit, addresses 00FF00h and 010000h sit on either side of the protection boundary.

// File: rtl/spi_write_guard.sv
module spi_write_guard #(
  parameter int BUSY_CYCLES = 1000,
  parameter int PROT_PAGES  = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        mosi,
  input  logic        wp_n,
  output logic        miso,
  output logic        op_start,
  output logic [7:0]  op_code,
  output logic [23:0] op_addr
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [15:0] PROT_LIM = 16'(PROT_PAGES);

  logic sck_q, cs_q;
  logic [2:0] bitc, bytec;
  logic [6:0] sr;
  logic [7:0] opc;
  logic [23:0] addr;
  logic wel, wip, dpd, miso_r;
  logic [CNT_W-1:0] busy;

  wire sck_rise = !cs_n && sck && !sck_q;
  wire sck_fall = !cs_n && !sck && sck_q;
  wire done     = !cs_q && cs_n;
  wire [7:0] byte_in = {sr, mosi};
  wire framed   = (bitc == 3'd0) && (bytec != 3'd0);
  wire is_mod   = opc inside {8'h0A, 8'h02, 8'hDB, 8'hD8};
  wire prot     = !wp_n && (addr[23:8] < PROT_LIM);
  wire go       = done && framed && is_mod && wel && !wip && !dpd
                  && (bytec >= 3'd4) && !prot;
  wire rd_sr    = (bytec != 3'd0) && (opc == 8'h05) && !dpd;

  assign miso = miso_r && !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1;
      bitc <= '0; bytec <= '0; sr <= '0; opc <= '0; addr <= '0;
      wel <= 1'b0; wip <= 1'b0; dpd <= 1'b0; miso_r <= 1'b0;
      busy <= '0;
      op_start <= 1'b0; op_code <= '0; op_addr <= '0;
    end else begin
      sck_q <= sck;
      cs_q <= cs_n;
      op_start <= go;
      if (cs_n) begin
        bitc <= '0;
        bytec <= '0;
        miso_r <= 1'b0;
      end else begin
        if (sck_rise) begin
          sr <= byte_in[6:0];
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) begin
            if (bytec != 3'd7) bytec <= bytec + 3'd1;
            if (bytec == 3'd0) opc <= byte_in;
            else if (bytec < 3'd4) addr <= {addr[15:0], byte_in};
          end
        end
        if (sck_fall)
          miso_r <= rd_sr && ((bitc == 3'd6 && wel) || (bitc == 3'd7 && wip));
      end
      if (go) begin
        wip <= 1'b1;
        busy <= CNT_W'(BUSY_CYCLES);
        op_code <= opc;
        op_addr <= addr;
      end else if (wip) begin
        if (busy <= 1) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end else begin
          busy <= busy - 1'b1;
        end
      end else if (done && framed) begin
        if (dpd) begin
          if (opc == 8'hAB) dpd <= 1'b0;
        end else begin
          case (opc)
            8'h06: wel <= 1'b1;
            8'h04: wel <= 1'b0;
            8'hB9: dpd <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  a_r2_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(wel));
  a_r3_start_whole_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> ($past(bitc) == 3'd0 && $past(bytec) >= 3'd4));
  a_r4_protected_pages: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> ($past(wp_n) || op_addr[23:8] >= PROT_LIM));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
  a_r6_no_start_in_dpd: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !$past(dpd));
  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> wip);
  a_r8_wel_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
endmodule

// File: tb/test_spi_write_guard.sv
module test_spi_write_guard;
  localparam int BUSY = 200;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic miso, op_start;
  logic [7:0] op_code;
  logic [23:0] op_addr;

  spi_write_guard #(.BUSY_CYCLES(BUSY)) i_spi_write_guard (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
    .miso(miso), .op_start(op_start), .op_code(op_code), .op_addr(op_addr));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  string tag = "R1";
  int m_wel = 0, m_wip_left = 0, m_dpd = 0;
  bit pend = 0, exp_start = 0;
  logic [7:0] p_code, exp_code;
  logic [23:0] p_addr, exp_addr;

  function automatic logic [7:0] model_status();
    return m_dpd != 0 ? 8'h00 : {6'b0, m_wel != 0, m_wip_left > 0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wel = 0; m_wip_left = 0; m_dpd = 0; exp_start = 0; pend = 0;
    end else begin
      exp_start = 0;
      if (pend) begin
        exp_start = 1; exp_code = p_code; exp_addr = p_addr;
        m_wip_left = BUSY; pend = 0;
      end else if (m_wip_left > 0) begin
        m_wip_left--;
        if (m_wip_left == 0) m_wel = 0;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (!rst_n) begin
      if (op_start !== 1'b0 || miso !== 1'b0) begin
        failures++;
        $display("FAIL R1 in reset: op_start=%b miso=%b expected 0 0", op_start, miso);
      end
    end else if (op_start !== exp_start ||
                 (exp_start && (op_code !== exp_code || op_addr !== exp_addr))) begin
      failures++;
      $display("FAIL %s start: got %b %h %h expected %b %h %h", tag,
               op_start, op_code, op_addr, exp_start, exp_code, exp_addr);
    end
  end

  task automatic decide(input logic [7:0] op, input logic [23:0] a, input int nbits);
    if (!rst_n || m_wip_left > 0 || pend) return;
    if (nbits == 0 || nbits % 8 != 0) return;
    if (m_dpd != 0) begin
      if (op == 8'hAB) m_dpd = 0;
      return;
    end
    case (op)
      8'h06: m_wel = 1;
      8'h04: m_wel = 0;
      8'hB9: m_dpd = 1;
      8'h0A, 8'h02, 8'hDB, 8'hD8:
        if (m_wel != 0 && nbits >= 32 && !(!wp_n && a[23:8] < 16'd256)) begin
          pend = 1; p_code = op; p_addr = a;
        end
      default: ;
    endcase
  endtask

  task automatic xfer(input logic [7:0] op, input logic [23:0] a, input int nbits);
    logic [7:0] snap = 8'h00;
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = i < 8 ? op[7-i] : i < 32 ? a[31-i] : i[0];
      repeat (2) @(negedge clk);
      if (op == 8'h05 && i >= 8) begin
        checks++;
        if (miso !== snap[7-((i-8)%8)]) begin
          failures++;
          $display("FAIL %s status bit %0d: got %b expected %b", tag, i, miso,
                   snap[7-((i-8)%8)]);
        end
      end
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
      snap = model_status();
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    decide(op, a, nbits);
    repeat (4) @(negedge clk);
  endtask

  task automatic rdsr(input string t);
    tag = t;
    xfer(8'h05, 24'h0, 24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rdsr("R1");
    tag = "R2"; xfer(8'h02, 24'h020000, 40);
    xfer(8'h06, 24'h0, 8);
    rdsr("R9");
    tag = "R2"; xfer(8'h04, 24'h0, 8);
    rdsr("R2");
    tag = "R2"; xfer(8'h02, 24'h020000, 40);
    xfer(8'h06, 24'h0, 8);
    tag = "R3"; xfer(8'h02, 24'h020000, 41);
    xfer(8'h02, 24'h020000, 16);
    xfer(8'h06, 24'h0, 7);
    rdsr("R3");
    wp_n = 1'b0;
    tag = "R4"; xfer(8'h02, 24'h00FF00, 40);
    tag = "R5"; xfer(8'h02, 24'h010000, 48);
    rdsr("R7");
    tag = "R7"; xfer(8'h04, 24'h0, 8);
    xfer(8'h0A, 24'h030000, 40);
    rdsr("R7");
    repeat (BUSY + 10) @(negedge clk);
    rdsr("R8");
    wp_n = 1'b1;
    tag = "R4"; xfer(8'h06, 24'h0, 8);
    xfer(8'hD8, 24'h000100, 32);
    repeat (BUSY + 10) @(negedge clk);
    tag = "R5"; xfer(8'h06, 24'h0, 8);
    xfer(8'hDB, 24'h0ABC00, 32);
    repeat (BUSY + 10) @(negedge clk);
    xfer(8'h06, 24'h0, 8);
    xfer(8'h0A, 24'hFFFFFF, 64);
    repeat (BUSY + 10) @(negedge clk);
    tag = "R6"; xfer(8'h06, 24'h0, 8);
    xfer(8'hB9, 24'h0, 8);
    rdsr("R6");
    tag = "R6"; xfer(8'h02, 24'h040000, 40);
    xfer(8'h04, 24'h0, 8);
    xfer(8'hAB, 24'h0, 8);
    rdsr("R6");
    tag = "R6"; xfer(8'h02, 24'h040000, 40);
    repeat (BUSY + 10) @(negedge clk);
    tag = "R1"; xfer(8'h06, 24'h0, 8);
    @(negedge clk) rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rdsr("R1");
    tag = "R1"; xfer(8'h02, 24'h050000, 40);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule